// File: doc/BRIEF.md
# 16-bit ALU with N/Z/C/V condition flags

This block performs the arithmetic, logic and single-bit shift operations of a small 16-bit processor. Two operands and a 4-bit operation code go in. A result, a destination write-enable and four condition flags come out. The result and the write-enable are combinational. The flags (negative, zero, carry and overflow) are held in a register that loads on a clock edge when the flag enable is high.

The stored carry feeds the add-with-carry and subtract-with-carry operations, so multi-word arithmetic can be chained. On subtraction the carry flag means borrow. Compare and test set the flags as subtract and AND would, but they hold the write-enable low, so the destination register is left untouched. The unused operation codes produce a zero result, write nothing and leave the flags alone.

Top module: `alu16_nzcv`

## Requirements
- R1: Code 1 (add) gives opa+opb modulo 2^16, C is the carry out of bit 15, and V is set when both operands have the same sign and the result sign differs.
- R2: Code 2 (sub) gives opa-opb modulo 2^16, C is set when opb is greater than opa as unsigned numbers (borrow), and V is set when the operand signs differ and the result sign differs from opa.
- R3: Code 3 gives opa+opb+C and code 4 gives opa-opb-C, where C is the stored carry flag. Carry, borrow and overflow follow R1 and R2 with the incoming carry included.
- R4: Code 5 (compare) sets the flags exactly as code 2 and code 13 (test) exactly as code 7. For both, wr_en is 0 and result shows the value computed.
- R5: Codes 6, 7 and 8 give bitwise OR, AND and XOR. V is cleared and C keeps its previous value.
- R6: Codes 9, 10 and 11 shift opa by one place: left, logical right (0 enters bit 15), and arithmetic right (bit 15 is kept). C takes the bit shifted out, V is cleared, and opb has no effect.
- R7: For every valid code, N is set equal to result bit 15 and Z is set when all 16 result bits are zero.
- R8: Codes 0, 12, 14 and 15 give result 0 and wr_en 0, and leave all four flags unchanged.
- R9: wr_en is 1 exactly for codes 1-4 and 6-11.
- R10: The flags load on a rising clk edge only when flag_en is 1, and hold otherwise. An active-low rst_n clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset, clears the flags |
| flag_en | input | 1 | Loads the computed flags on the next rising edge |
| op | input | 4 | Operation code |
| opa | input | 16 | First operand; also the shift source |
| opb | input | 16 | Second operand |
| result | output | 16 | Combinational result |
| wr_en | output | 1 | Destination write-enable |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry/borrow flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
On every cycle the assertions check the following: N and Z track the previous result, flags hold when loading is disabled or the code is unused, logic operations preserve C and clear V, and compare, test and unused codes never raise wr_en. Only the bench scenarios can show the arithmetic values themselves. These include the carry and borrow at the 16-bit boundary, signed overflow in both directions, chained add-with-carry and subtract-with-carry across words, and the bit that each shift moves into C.

// File: rtl/alu16_pkg.sv
// Shared operation codes and flag type for the 16-bit ALU.
// Assumes a 4-bit operation field; unlisted codes are treated as unused.
package alu16_pkg;
    localparam logic [3:0] OPC_ADD = 4'd1;
    localparam logic [3:0] OPC_SUB = 4'd2;
    localparam logic [3:0] OPC_ADC = 4'd3;
    localparam logic [3:0] OPC_SBC = 4'd4;
    localparam logic [3:0] OPC_CMP = 4'd5;
    localparam logic [3:0] OPC_OR  = 4'd6;
    localparam logic [3:0] OPC_AND = 4'd7;
    localparam logic [3:0] OPC_XOR = 4'd8;
    localparam logic [3:0] OPC_SHL = 4'd9;
    localparam logic [3:0] OPC_LSR = 4'd10;
    localparam logic [3:0] OPC_ASR = 4'd11;
    localparam logic [3:0] OPC_TST = 4'd13;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic [1:0] {LG_OR = 2'd0, LG_AND = 2'd1, LG_XOR = 2'd2} logic_sel_e;
    typedef enum logic [1:0] {SH_LEFT = 2'd0, SH_LOG = 2'd1, SH_ARITH = 2'd2} shift_sel_e;
endpackage

// File: rtl/alu16_addsub.sv
// Adder/subtractor with carry-in. In subtract mode the carry output is a
// borrow. Assumes the caller zeroes cin when no carry is to be used.
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int EW = W + 1;
    logic [EW-1:0] ext;

    // Compute the extended sum or difference and the signed overflow.
    always_comb begin
        if (sub)
            ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        else
            ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = ext[W-1:0];
        cout = ext[W];
        if (sub)
            ovf = (a[W-1] ^ b[W-1]) & (ext[W-1] ^ a[W-1]);
        else
            ovf = ~(a[W-1] ^ b[W-1]) & (ext[W-1] ^ a[W-1]);
    end
endmodule

// File: rtl/alu16_bitwise.sv
// Bitwise OR / AND / XOR, one generated slice per bit.
module alu16_bitwise #(
    parameter int W = 16
) (
    input  logic [W-1:0]          a,
    input  logic [W-1:0]          b,
    input  alu16_pkg::logic_sel_e sel,
    output logic [W-1:0]          y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Pick the bit operation for this slice.
        always_comb begin
            case (sel)
                alu16_pkg::LG_AND: y[i] = a[i] & b[i];
                alu16_pkg::LG_XOR: y[i] = a[i] ^ b[i];
                default:           y[i] = a[i] | b[i];
            endcase
        end
    end
endmodule

// File: rtl/alu16_shift1.sv
// One-place shifter: left, logical right or arithmetic right.
// The bit shifted out is returned on bit_out.
module alu16_shift1 #(
    parameter int W = 16
) (
    input  logic [W-1:0]          a,
    input  alu16_pkg::shift_sel_e sel,
    output logic [W-1:0]          y,
    output logic                  bit_out
);
    // Form the shifted word and capture the lost bit.
    always_comb begin
        case (sel)
            alu16_pkg::SH_LEFT: begin
                y       = {a[W-2:0], 1'b0};
                bit_out = a[W-1];
            end
            alu16_pkg::SH_ARITH: begin
                y       = {a[W-1], a[W-1:1]};
                bit_out = a[0];
            end
            default: begin
                y       = {1'b0, a[W-1:1]};
                bit_out = a[0];
            end
        endcase
    end
endmodule

// File: rtl/alu16_flagreg.sv
// Condition flag register with load enable and synchronous active-low reset.
module alu16_flagreg (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  alu16_pkg::nzcv_t  d,
    output alu16_pkg::nzcv_t  q
);
    // Hold or load the four flags each clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/alu16_nzcv.sv
// 16-bit ALU top: decodes the operation code, steers the datapath units,
// forms the next N/Z/C/V flags and keeps them in a register. Assumes
// result and wr_en are consumed in the same cycle as the operands.
module alu16_nzcv #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flag_en,
    input  logic [3:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v
);
    import alu16_pkg::*;

    nzcv_t       cur, nxt;
    logic        as_sub, as_cin, as_cout, as_ovf;
    logic [W-1:0] as_sum, lg_y, sh_y;
    logic        sh_out, valid;
    logic_sel_e  lg_sel;
    shift_sel_e  sh_sel;

    // Select adder mode and carry-in from the operation code.
    always_comb begin
        as_sub = (op == OPC_SUB) || (op == OPC_SBC) || (op == OPC_CMP);
        as_cin = ((op == OPC_ADC) || (op == OPC_SBC)) ? cur.c : 1'b0;
    end

    // Select the bitwise and shift variants.
    always_comb begin
        case (op)
            OPC_AND, OPC_TST: lg_sel = LG_AND;
            OPC_XOR:          lg_sel = LG_XOR;
            default:          lg_sel = LG_OR;
        endcase
        case (op)
            OPC_SHL: sh_sel = SH_LEFT;
            OPC_ASR: sh_sel = SH_ARITH;
            default: sh_sel = SH_LOG;
        endcase
    end

    alu16_addsub #(.W(W)) u_as (
        .a(opa), .b(opb), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
    );

    alu16_bitwise #(.W(W)) u_lg (
        .a(opa), .b(opb), .sel(lg_sel), .y(lg_y)
    );

    alu16_shift1 #(.W(W)) u_sh (
        .a(opa), .sel(sh_sel), .y(sh_y), .bit_out(sh_out)
    );

    // Choose the result, write-enable and the C/V part of the next flags.
    always_comb begin
        result = '0;
        wr_en  = 1'b0;
        valid  = 1'b1;
        nxt    = cur;
        case (op)
            OPC_ADD, OPC_SUB, OPC_ADC, OPC_SBC: begin
                result = as_sum; wr_en = 1'b1;
                nxt.c = as_cout; nxt.v = as_ovf;
            end
            OPC_CMP: begin
                result = as_sum;
                nxt.c = as_cout; nxt.v = as_ovf;
            end
            OPC_OR, OPC_AND, OPC_XOR: begin
                result = lg_y; wr_en = 1'b1;
                nxt.v = 1'b0;
            end
            OPC_TST: begin
                result = lg_y;
                nxt.v = 1'b0;
            end
            OPC_SHL, OPC_LSR, OPC_ASR: begin
                result = sh_y; wr_en = 1'b1;
                nxt.c = sh_out; nxt.v = 1'b0;
            end
            default: valid = 1'b0;
        endcase
        if (valid) begin
            nxt.n = result[W-1];
            nxt.z = (result == '0);
        end
    end

    alu16_flagreg u_fr (
        .clk(clk), .rst_n(rst_n), .load(flag_en), .d(nxt), .q(cur)
    );

    // Drive the flag outputs from the register.
    always_comb begin
        flag_n = cur.n;
        flag_z = cur.z;
        flag_c = cur.c;
        flag_v = cur.v;
    end
endmodule

// File: rtl/alu16_nzcv_chk.sv
// Port-level checker for alu16_nzcv, attached with bind below.
module alu16_nzcv_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         flag_en,
    input logic [3:0]   op,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [W-1:0] result,
    input logic         wr_en,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_v
);
    logic unused_op, logic_op, nowrite_op;
    logic started;

    // Classify the current code independently of the design's decoder.
    always_comb begin
        unused_op  = (op == 4'd0) || (op == 4'd12) || (op == 4'd14) || (op == 4'd15);
        logic_op   = (op == 4'd6) || (op == 4'd7) || (op == 4'd8) || (op == 4'd13);
        nowrite_op = (op == 4'd5) || (op == 4'd13) || unused_op;
    end

    // Mark the first cycle after reset so $past is never taken across it.
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    AST_NO_WRITE_CMP_TST: assert property (@(posedge clk) disable iff (!rst_n)
        nowrite_op |-> !wr_en);                                            // R4
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unused_op |-> (result == '0));                                     // R8
    AST_UNUSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (started && unused_op) |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R8
    AST_EN_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !flag_en) |=> $stable({flag_n, flag_z, flag_c, flag_v}));  // R10
    AST_NZ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (started && flag_en && !unused_op) |=>
            (flag_n == $past(result[W-1])) && (flag_z == ($past(result) == '0))); // R7
    AST_LOGIC_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (started && flag_en && logic_op) |=> (!flag_v && flag_c == $past(flag_c))); // R5
endmodule

bind alu16_nzcv alu16_nzcv_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flag_en(flag_en), .op(op), .opa(opa), .opb(opb),
    .result(result), .wr_en(wr_en), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/sim_alu16_nzcv.sv
module sim_alu16_nzcv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_en = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [15:0] opa = '0, opb = '0;
    logic [15:0] result;
    logic        wr_en, flag_n, flag_z, flag_c, flag_v;

    int vectors = 0;
    int fails = 0;
    logic done = 1'b0;
    logic [3:0] mflags = 4'b0000;   // model {N,Z,C,V}

    always #4 clk = ~clk;   // 125 MHz

    alu16_nzcv u0 (
        .clk(clk), .rst_n(rst_n), .flag_en(flag_en), .op(op), .opa(opa), .opb(opb),
        .result(result), .wr_en(wr_en), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    function automatic void check(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endfunction

    // Reference model from the requirements: returns {res, wr, N, Z, C, V}.
    function automatic logic [21:0] model(logic [3:0] o, logic [15:0] a, logic [15:0] b,
                                          logic [3:0] fl);
        int unsigned ua = a, ub = b, ci = fl[1], t;
        logic [15:0] r = 16'h0;
        logic wr = 1'b0, c = fl[1], v = fl[0], n = fl[3], z = fl[2], ok = 1'b1;
        case (o)
            4'd1, 4'd3: begin
                t = ua + ub + ((o == 4'd3) ? ci : 0);
                r = t[15:0]; c = (t > 32'hFFFF);
                v = (a[15] == b[15]) && (r[15] != a[15]); wr = 1'b1;
            end
            4'd2, 4'd4, 4'd5: begin
                t = ((o == 4'd4) ? ci : 0);
                r = 16'(ua - ub - t); c = (ua < ub + t);
                v = (a[15] != b[15]) && (r[15] != a[15]); wr = (o != 4'd5);
            end
            4'd6:  begin r = a | b; v = 1'b0; wr = 1'b1; end
            4'd7:  begin r = a & b; v = 1'b0; wr = 1'b1; end
            4'd13: begin r = a & b; v = 1'b0; end
            4'd8:  begin r = a ^ b; v = 1'b0; wr = 1'b1; end
            4'd9:  begin r = 16'(ua * 2); c = a[15]; v = 1'b0; wr = 1'b1; end
            4'd10: begin r = 16'(ua / 2); c = a[0]; v = 1'b0; wr = 1'b1; end
            4'd11: begin r = 16'(ua / 2) | (a & 16'h8000); c = a[0]; v = 1'b0; wr = 1'b1; end
            default: ok = 1'b0;
        endcase
        if (ok) begin n = r[15]; z = (r == 16'h0); end
        return {r, wr, 1'b0, n, z, c, v};
    endfunction

    // Apply one vector, check the combinational outputs, then the flags.
    task automatic step(string req, logic [3:0] o, logic [15:0] a, logic [15:0] b, logic en);
        logic [21:0] e;
        @(negedge clk);
        op = o; opa = a; opb = b; flag_en = en;
        #1;
        e = model(o, a, b, mflags);
        check(req, "result", int'(result), int'(e[21:6]));
        check(req, "wr_en", int'(wr_en), int'(e[5]));
        @(posedge clk);
        #1;
        if (en) mflags = e[3:0];
        check(req, "flags", int'({flag_n, flag_z, flag_c, flag_v}), int'(mflags));
    endtask

    task automatic t_reset();
        check("R10", "reset flags", int'({flag_n, flag_z, flag_c, flag_v}), 0);
    endtask

    task automatic t_add();
        step("R1", 4'd1, 16'h1234, 16'h1111, 1);
        step("R1", 4'd1, 16'hFFFF, 16'h0001, 1);   // carry + zero
        step("R1", 4'd1, 16'h7FFF, 16'h0001, 1);   // signed overflow
        step("R1", 4'd1, 16'h8000, 16'h8000, 1);   // carry + overflow + zero
    endtask

    task automatic t_sub();
        step("R2", 4'd2, 16'h0005, 16'h0003, 1);
        step("R2", 4'd2, 16'h0003, 16'h0005, 1);   // borrow
        step("R2", 4'd2, 16'h8000, 16'h0001, 1);   // overflow
        step("R2", 4'd2, 16'h4444, 16'h4444, 1);   // zero
    endtask

    task automatic t_carry_chain();
        step("R3", 4'd1, 16'hFFFF, 16'h0002, 1);   // C=1
        step("R3", 4'd3, 16'h0000, 16'h0000, 1);   // 0+0+1
        step("R3", 4'd2, 16'h0000, 16'h0001, 1);   // borrow set
        step("R3", 4'd4, 16'h0010, 16'h0005, 1);   // 16-5-1
        step("R3", 4'd4, 16'h0000, 16'h0000, 1);   // C=0 -> 0
        step("R3", 4'd2, 16'h0000, 16'h0001, 1);
        step("R3", 4'd4, 16'h0000, 16'hFFFF, 1);   // 0-FFFF-1 borrow
    endtask

    task automatic t_cmp_tst();
        step("R4", 4'd5, 16'h0002, 16'h0009, 1);
        step("R4", 4'd5, 16'h0009, 16'h0009, 1);
        step("R4", 4'd13, 16'hF0F0, 16'h0F0F, 1);
        step("R4", 4'd13, 16'h8001, 16'hFF00, 1);
    endtask

    task automatic t_logic();
        step("R5", 4'd1, 16'hFFFF, 16'h0001, 1);   // C=1
        step("R5", 4'd6, 16'hA000, 16'h0005, 1);
        step("R5", 4'd7, 16'h00FF, 16'h0F0F, 1);
        step("R5", 4'd8, 16'h5A5A, 16'h5A5A, 1);
        step("R5", 4'd2, 16'h0009, 16'h0001, 1);   // C=0
        step("R5", 4'd8, 16'hFFFF, 16'h0000, 1);
    endtask

    task automatic t_shifts();
        step("R6", 4'd9,  16'h8001, 16'hFFFF, 1);
        step("R6", 4'd9,  16'h4000, 16'h0000, 1);
        step("R6", 4'd10, 16'h8001, 16'h1234, 1);
        step("R6", 4'd10, 16'h0001, 16'h0000, 1);
        step("R6", 4'd11, 16'h8002, 16'hFFFF, 1);
        step("R6", 4'd11, 16'h7FFF, 16'h0000, 1);
    endtask

    task automatic t_unused();
        step("R8", 4'd1, 16'h8000, 16'h8000, 1);   // nonzero flags
        step("R8", 4'd0,  16'h1234, 16'h5678, 1);
        step("R8", 4'd12, 16'hFFFF, 16'hFFFF, 1);
        step("R8", 4'd14, 16'h0000, 16'h0000, 1);
        step("R8", 4'd15, 16'h8000, 16'h0001, 1);
    endtask

    task automatic t_enable();
        step("R10", 4'd2, 16'h0000, 16'h0001, 1);
        step("R10", 4'd1, 16'h0001, 16'h0001, 0);  // flags must hold
        step("R10", 4'd9, 16'h0000, 16'h0000, 0);
        step("R10", 4'd1, 16'h0001, 16'h0001, 1);
    endtask

    task automatic t_sweep();
        logic [15:0] lf = 16'hACE1;
        for (int k = 0; k < 64; k++) begin
            logic [15:0] a, b;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a = lf;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            b = lf;
            step("R9", 4'(k % 16), a, b, 1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_carry_chain();
        t_cmp_tst();
        t_logic();
        t_shifts();
        t_unused();
        t_enable();
        t_sweep();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                vectors++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule